// File: doc/BRIEF.md
# Clock Generator Configuration Slave

This block is the two-wire (I2C) target that configures a spread-spectrum clock generator. It holds two 8-bit working registers whose fields drive the generator directly:

- the divider exponent, the modulation-rate select and the powered-down output level;
- the spread-amount select, the software output enable, the persistence mode bit and the three low address bits.

The block samples SCL and SDA with the system clock. It pulls SDA low for acknowledge bits and for zero read bits.

A second pair of registers stands in for nonvolatile storage, and the working registers reload from it at reset. A commit copies working registers into the store, and it is only decided when a STOP is seen. The address register is always committed. The divider register is committed automatically, or only on an explicit command when the manual-commit bit is set. After each accepted commit, a busy timer blocks further commits for a fixed number of cycles.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The block acknowledges only the 7-bit target address 1011 followed by the low three bits of the address register (bits [2:0]); any other address is left unacknowledged and its transfer is ignored.
- R2: Register 02h is the divider register: bits [7:6] give `rate_sel`, bit 5 gives `park_low`, and bits [3:0] give the divider exponent. A data byte written there appears on the outputs after its acknowledge.
- R3: Register 0Dh is the address register: bits [7:6] give `spread_sel`, bit 5 gives `sw_enable`, bit 3 gives `manual_commit`, and bits [2:0] give `addr_lo`.
- R4: `div_exp` equals the divider field when the field is 8 or less, and equals 8 for any larger field.
- R5: A random read (address+write, register address, repeated START, address+read, one byte that the master NACKs, STOP) returns the current value of the addressed register.
- R6: Register addresses other than 02h, 0Dh and 3Fh are acknowledged, change no register and start no commit; reads from them return 00h.
- R7: With `manual_commit` = 0, a divider-register write is copied into `store_pre` at the STOP that ends its transfer.
- R8: With `manual_commit` = 1, a divider-register write leaves `store_pre` unchanged. A write transfer that names register 3Fh copies both working registers into the store at its STOP.
- R9: A write to the address register is copied into `store_adr` at STOP, whatever the value of `manual_commit`.
- R10: No stored value changes before the STOP of the transfer that caused the commit.
- R11: An accepted commit holds `store_busy` high for exactly BUSY_CYC cycles. A STOP that arrives while `store_busy` is high commits nothing.
- R12: At reset, the address register loads from `store_adr`. The divider register loads from `store_pre` with its divider field forced to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; reloads the working registers from the store |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High to pull SDA low |
| rate_sel | output | 2 | Modulation-rate select |
| park_low | output | 1 | Output level when powered down: 1 driven low, 0 floating |
| div_exp | output | 4 | Divider exponent, clamped to 8 |
| spread_sel | output | 2 | Spread-amount select |
| sw_enable | output | 1 | Software output enable |
| manual_commit | output | 1 | Persistence mode: 1 commits only on command |
| addr_lo | output | 3 | Low three bits of the target address |
| store_pre | output | 8 | Stored image of the divider register |
| store_adr | output | 8 | Stored image of the address register |
| store_busy | output | 1 | Store write in progress |

## Verification
The bench probes the store on both sides of STOP. A design that committed at the data acknowledge would show the new stored value before STOP.

It reprograms the address bits and then talks to the old address. A design that compared against a constant would keep acknowledging the old address.

It sends back-to-back commits inside the busy window and commands under both persistence modes. A design that ignored the busy timer, or that let the mode bit gate the address register, would store values it must drop.

It applies reset after uncommitted edits, random divider fields above 8, and reads of unmapped addresses. These expose a missing clamp, a reload from the working copy, or stray data on reads of empty locations.

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave #(
  parameter int          BUSY_CYC = 2000,
  parameter logic [7:0]  DEF_PRE  = 8'h45,
  parameter logic [7:0]  DEF_ADR  = 8'h00,
  parameter logic [7:0]  PRE_LOC  = 8'h02,
  parameter logic [7:0]  ADR_LOC  = 8'h0D,
  parameter logic [7:0]  CMD_LOC  = 8'h3F,
  parameter logic [3:0]  DEV_HI   = 4'b1011,
  parameter logic [3:0]  DIV_MAX  = 4'd8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [1:0] rate_sel,
  output logic       park_low,
  output logic [3:0] div_exp,
  output logic [1:0] spread_sel,
  output logic       sw_enable,
  output logic       manual_commit,
  output logic [2:0] addr_lo,
  output logic [7:0] store_pre,
  output logic [7:0] store_adr,
  output logic       store_busy
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_WDAT, S_RD, S_RACK, S_IGN} st_t;

  st_t         st;
  logic [2:0]  scl_s, sda_s;
  logic [3:0]  bcnt;
  logic [7:0]  sh, ptr, pre, adr, rdata;
  logic [7:0]  nv_pre = DEF_PRE;
  logic [7:0]  nv_adr = DEF_ADR;
  logic        ack_drv, sda_low, pre_dirty, adr_dirty, cmd_hit;
  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire rise  = scl_s[1] & ~scl_s[2];
  wire fall  = ~scl_s[1] & scl_s[2];
  wire start = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  wire stop  = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];
  wire rx_st = (st == S_DEV) || (st == S_REG) || (st == S_WDAT);

  assign rdata = (ptr == PRE_LOC) ? pre : (ptr == ADR_LOC) ? adr : 8'h00;

  wire go         = stop && (busy_cnt == '0);
  wire commit_adr = go && (adr_dirty || cmd_hit);
  wire commit_pre = go && (cmd_hit || (pre_dirty && !adr[3]));

  always_ff @(posedge clk) begin
    if (commit_pre) nv_pre <= pre;
    if (commit_adr) nv_adr <= adr;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      bcnt <= '0;
      sh <= '0;
      ptr <= '0;
      ack_drv <= 1'b0;
      sda_low <= 1'b0;
      pre <= {nv_pre[7:4], 4'b0000};
      adr <= nv_adr;
      pre_dirty <= 1'b0;
      adr_dirty <= 1'b0;
      cmd_hit <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (commit_pre || commit_adr) busy_cnt <= BW'(BUSY_CYC);
      else if (busy_cnt != '0)      busy_cnt <= busy_cnt - 1'b1;

      if (start) begin
        st <= S_DEV;
        bcnt <= '0;
        ack_drv <= 1'b0;
        sda_low <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE;
        ack_drv <= 1'b0;
        sda_low <= 1'b0;
        pre_dirty <= 1'b0;
        adr_dirty <= 1'b0;
        cmd_hit <= 1'b0;
      end else if (rise && !ack_drv) begin
        case (st)
          S_DEV, S_REG, S_WDAT:
            if (bcnt < 4'd8) begin
              sh <= {sh[6:0], sda_s[1]};
              bcnt <= bcnt + 1'b1;
            end
          S_RD:
            if (bcnt < 4'd8) bcnt <= bcnt + 1'b1;
          S_RACK:
            if (sda_s[1]) st <= S_IGN;
            else begin
              st <= S_RD;
              bcnt <= '0;
            end
          default: ;
        endcase
      end else if (fall) begin
        if (ack_drv) begin
          ack_drv <= 1'b0;
          sda_low <= (st == S_RD) ? ~rdata[7] : 1'b0;
        end else if (rx_st && bcnt == 4'd8) begin
          bcnt <= '0;
          ack_drv <= 1'b1;
          sda_low <= 1'b1;
          case (st)
            S_DEV:
              if (sh[7:1] == {DEV_HI, adr[2:0]}) st <= sh[0] ? S_RD : S_REG;
              else begin
                st <= S_IGN;
                ack_drv <= 1'b0;
                sda_low <= 1'b0;
              end
            S_REG: begin
              ptr <= sh;
              st <= S_WDAT;
              if (sh == CMD_LOC) cmd_hit <= 1'b1;
            end
            default:
              if (ptr == PRE_LOC) begin
                pre <= sh;
                pre_dirty <= 1'b1;
              end else if (ptr == ADR_LOC) begin
                adr <= sh;
                adr_dirty <= 1'b1;
              end
          endcase
        end else if (st == S_RD) begin
          if (bcnt < 4'd8) sda_low <= ~rdata[3'd7 - bcnt[2:0]];
          else begin
            sda_low <= 1'b0;
            st <= S_RACK;
          end
        end
      end
    end

  assign sda_oe        = sda_low;
  assign rate_sel      = pre[7:6];
  assign park_low      = pre[5];
  assign div_exp       = (pre[3:0] > DIV_MAX) ? DIV_MAX : pre[3:0];
  assign spread_sel    = adr[7:6];
  assign sw_enable     = adr[5];
  assign manual_commit = adr[3];
  assign addr_lo       = adr[2:0];
  assign store_pre     = nv_pre;
  assign store_adr     = nv_adr;
  assign store_busy    = (busy_cnt != '0);
endmodule

// File: rtl/clkgen_cfg_slave_chk.sv
module clkgen_cfg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] div_exp,
  input logic [2:0] addr_lo,
  input logic [7:0] store_pre,
  input logic [7:0] store_adr,
  input logic       store_busy
);
  AST_DIV_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    div_exp <= 4'd8); // R4

  AST_STORE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(store_busy) |-> ($stable(store_pre) && $stable(store_adr))); // R11

  AST_STORE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(store_pre) || !$stable(store_adr)) |-> store_busy); // R11

  AST_RESET_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (div_exp == 4'd0 && addr_lo == store_adr[2:0])); // R12
endmodule

bind clkgen_cfg_slave clkgen_cfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_exp(div_exp), .addr_lo(addr_lo),
  .store_pre(store_pre), .store_adr(store_adr), .store_busy(store_busy)
);

// File: tb/clkgen_cfg_slave_bench.sv
`timescale 1ns/1ps
module clkgen_cfg_slave_bench;
  localparam int BUSY = 3000;
  localparam int Q    = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  wire  sda_oe;
  wire  sda_line = m_sda & ~sda_oe;
  logic [1:0] rate_sel, spread_sel;
  logic park_low, sw_enable, manual_commit, store_busy;
  logic [3:0] div_exp;
  logic [2:0] addr_lo;
  logic [7:0] store_pre, store_adr;
  int n_chk = 0, n_bad = 0, busy_len = 0;

  always #4 clk = ~clk;

  clkgen_cfg_slave #(.BUSY_CYC(BUSY), .DEF_PRE(8'h45), .DEF_ADR(8'h00)) u_clkgen_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .rate_sel(rate_sel), .park_low(park_low), .div_exp(div_exp),
    .spread_sel(spread_sel), .sw_enable(sw_enable), .manual_commit(manual_commit),
    .addr_lo(addr_lo), .store_pre(store_pre), .store_adr(store_adr),
    .store_busy(store_busy)
  );

  always @(negedge clk) if (store_busy) busy_len++;

  function automatic logic [3:0] exp_div(logic [7:0] v);
    return (v[3:0] > 4'd8) ? 4'd8 : v[3:0];
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pre(string req, logic [7:0] v);
    chk(req, {rate_sel, park_low, div_exp}, {v[7:6], v[5], exp_div(v)});
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = !sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); m_sda = !mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q); m_sda = 1'b1;
  endtask

  task automatic wr(logic [2:0] lo, logic [7:0] ptr, logic [7:0] d, bit with_data,
                    bit with_stop, output logic ok);
    logic a0, a1, a2;
    a2 = 1'b1;
    i2c_start;
    send_byte({4'b1011, lo, 1'b0}, a0);
    if (a0) begin
      send_byte(ptr, a1);
      if (with_data) send_byte(d, a2);
    end else a1 = 1'b0;
    if (with_stop) i2c_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic rd(logic [2:0] lo, logic [7:0] ptr, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start;
    send_byte({4'b1011, lo, 1'b0}, a0);
    send_byte(ptr, a1);
    i2c_start;
    send_byte({4'b1011, lo, 1'b1}, a2);
    recv_byte(1'b0, d);
    i2c_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic wait_idle;
    while (store_busy) tick(1);
    tick(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ok;
    logic [7:0] d, v;
    logic [2:0] wlo;
    void'($urandom(32'd1089));
    tick(5); rst_n = 1'b1; tick(3);

    // R12 reset: divider field zero, other fields from store
    chk_pre("R12", 8'h40);
    chk("R12 addr_lo", addr_lo, 0);
    chk("R12 busy", store_busy, 0);
    chk("R12 store", store_pre, 8'h45);

    // R2 / R10: data applied before stop, store untouched until stop
    busy_len = 0;
    wr(3'd0, 8'h02, 8'h83, 1, 0, ok);
    chk("R2 ack", ok, 1);
    chk_pre("R2", 8'h83);
    tick(20);
    chk("R10 before stop", store_pre, 8'h45);
    i2c_stop;
    chk("R7 commit", store_pre, 8'h83);
    chk("R11 busy set", store_busy, 1);
    wait_idle;
    chk("R11 busy length", busy_len, BUSY);

    // R11: a commit requested during busy is dropped
    wr(3'd0, 8'h02, 8'h81, 1, 1, ok);
    wr(3'd0, 8'h02, 8'h07, 1, 1, ok);
    chk_pre("R11 working", 8'h07);
    chk("R11 dropped", store_pre, 8'h81);
    wait_idle;

    // R4 / R5 / R7: random divider values, read back, auto commit
    for (int i = 0; i < 6; i++) begin
      v = 8'($urandom);
      if (i == 0) v[3:0] = 4'hF;
      if (i == 1) v[3:0] = 4'h8;
      wr(3'd0, 8'h02, v, 1, 1, ok);
      chk_pre("R4", v);
      chk("R7 auto", store_pre, v);
      rd(3'd0, 8'h02, d, ok);
      chk("R5 ack", ok, 1);
      chk("R5 data", d, v);
      wait_idle;
    end

    // R3 / R9: address register fields and immediate store
    wr(3'd0, 8'h0D, 8'hAD, 1, 1, ok);
    chk("R3 fields", {spread_sel, sw_enable, manual_commit, addr_lo}, {2'b10, 1'b1, 1'b1, 3'b101});
    chk("R9 store", store_adr, 8'hAD);
    wait_idle;
    rd(3'd5, 8'h0D, d, ok);
    chk("R5 adr read", d, 8'hAD);

    // R1: wrong low address bits are not acknowledged
    for (int i = 0; i < 4; i++) begin
      wlo = 3'($urandom);
      if (wlo == 3'd5) wlo = 3'd0;
      wr(wlo, 8'h02, 8'hFF, 1, 1, ok);
      chk("R1 nack", ok, 0);
    end
    chk("R1 unchanged", div_exp, exp_div(v));
    wr(3'd5, 8'h02, 8'h42, 1, 1, ok);
    chk("R1 ack", ok, 1);

    // R8: manual mode keeps store; command commits both
    chk_pre("R8 working", 8'h42);
    chk("R8 no commit", store_pre, v);
    chk("R8 no busy", store_busy, 0);
    wr(3'd5, 8'h3F, 8'h00, 0, 1, ok);
    chk("R8 cmd ack", ok, 1);
    chk("R8 cmd pre", store_pre, 8'h42);
    chk("R8 cmd adr", store_adr, 8'hAD);
    wait_idle;

    // R6: unmapped register
    wr(3'd5, 8'h10, 8'hFF, 1, 1, ok);
    chk("R6 ack", ok, 1);
    chk_pre("R6 pre", 8'h42);
    chk("R6 adr", {spread_sel, sw_enable, manual_commit, addr_lo}, {2'b10, 1'b1, 1'b1, 3'b101});
    chk("R6 no commit", store_busy, 0);
    rd(3'd5, 8'h10, d, ok);
    chk("R6 read", d, 8'h00);

    // R9: address register stored even in manual mode
    wr(3'd5, 8'h0D, 8'h2D, 1, 1, ok);
    chk("R9 manual", store_adr, 8'h2D);
    wait_idle;

    // R12: uncommitted edit lost at reset
    wr(3'd5, 8'h02, 8'h5C, 1, 1, ok);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    chk_pre("R12 reload", 8'h40);
    chk("R12 adr reload", {spread_sel, sw_enable, manual_commit, addr_lo}, {2'b00, 1'b1, 1'b1, 3'b101});

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule